// File: doc/BRIEF.md
# Real-Time Seconds Timer

This block is a free-running real-time timer seen by software as four 32-bit registers on a simple synchronous read/write bus. A slow reference clock, such as a 32 kHz crystal, is brought in on its own pin. It is synchronized into the bus clock domain, and its rising edges are divided by a programmable prescaler. Each time the prescaler completes a period, an up-counter advances by one. With the prescaler set to the slow clock rate, the counter therefore counts seconds. Software cannot load the counter. It can only restart it from zero, so wall-clock time is kept as this count plus a base value stored elsewhere.

An alarm register is compared with the counter every time it advances. Two sticky status flags record an alarm match and a counter advance. A level interrupt is raised while a flag is set and its enable is on. Reading the status register clears both flags. An event that lands in the same cycle as that read is kept, so it is not lost. The alarm register resets to all ones, which software treats as "no alarm".

The whole counter lives in the bus clock domain, fed only by the synchronized edge pulse. A bus read of the value register therefore always returns one settled count and never a mix of two counts.

Top module: `rtt_timer`

## Requirements
- R1: After reset, the mode register reads 0, the alarm register (offset 0x04) reads 0xFFFFFFFF, the value register (offset 0x08) reads 0, the status register (offset 0x0C) reads 0, and the interrupt output is low.
- R2: The mode register (offset 0x00) holds the prescaler in bits [15:0]. With the prescaler set to P (nonzero), the counter increases by exactly one after every P rising edges of the slow clock.
- R3: A prescaler value of 0 gives a period of 2^PRESC_W slow-clock edges (65536 by default).
- R4: Writing the mode register with bit 18 set clears both the counter and the prescaler phase, so counting restarts from zero. Bit 18 always reads back as 0.
- R5: The value register is read-only. A bus write to offset 0x08 leaves the count unchanged.
- R6: After reaching its all-ones value, the counter wraps to 0 on the next advance and keeps counting.
- R7: Status bit 1 (increment flag) is set on every counter advance and stays set until the status register is read.
- R8: Status bit 0 (alarm flag) is set when the counter advances to a value equal to the alarm register, and not before.
- R9: A read of the status register clears both flags. A flag whose event occurs in the same cycle as that read stays set.
- R10: The interrupt output is a level. It is high while (status bit 0 and mode bit 16) or (status bit 1 and mode bit 17) is true, and low otherwise.
- R11: Each slow-clock rising edge is counted exactly once. Between two reads, the count changes only by +1 per advance or to 0 on a restart or wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk_i | input | 1 | Slow reference clock, asynchronous to clk |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the timer with a 4-bit counter and a 4-bit prescaler, keeping the two-stage synchronizer. Two cases become reachable in a short run. The counter wrap from all ones to zero takes only sixteen advances. The zero-prescaler period of sixteen slow edges can be walked edge by edge. The same-cycle collision between a status read and a counter advance is placed by counting the synchronizer and edge-detect registers from the slow-clock pin.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFF_MODE   = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_ALARM  = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_VALUE  = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 4'hC;

    localparam int MODE_PRESC_W = 16;
    localparam int BIT_ALM_EN   = 16;
    localparam int BIT_INC_EN   = 17;
    localparam int BIT_RESTART  = 18;

    localparam int BIT_ALM_FLAG = 0;
    localparam int BIT_INC_FLAG = 1;

    localparam logic [BUS_W-1:0] ALARM_OFF = '1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_ALARM,
        SEL_VALUE,
        SEL_STATUS
    } reg_sel_e;

    typedef struct packed {
        logic inc_en;
        logic alm_en;
    } irq_en_t;

    typedef struct packed {
        logic inc;
        logic alm;
    } flags_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_MODE:   return SEL_MODE;
            OFF_ALARM:  return SEL_ALARM;
            OFF_VALUE:  return SEL_VALUE;
            OFF_STATUS: return SEL_STATUS;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rtt_edge_sync.sv
module rtt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic tick_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= async_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[STAGES-1];
    end

    assign tick_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/rtt_prescaler.sv
module rtt_prescaler #(
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_i,
    input  logic               restart_i,
    input  logic [PRESC_W-1:0] period_i,
    output logic               adv_o,
    output logic [PRESC_W-1:0] phase_o
);
    logic [PRESC_W-1:0] phase_q;
    logic [PRESC_W-1:0] last_phase;

    // period 0 wraps to all ones, giving 2^PRESC_W edges per advance
    assign last_phase = period_i - 1'b1;
    assign adv_o      = tick_i && !restart_i && (phase_q == last_phase);

    always_ff @(posedge clk) begin
        if (rst || restart_i)  phase_q <= '0;
        else if (adv_o)        phase_q <= '0;
        else if (tick_i)       phase_q <= phase_q + 1'b1;
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/rtt_counter.sv
module rtt_counter
    import rtt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    input  logic             restart_i,
    input  logic [BUS_W-1:0] alarm_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             alarm_hit_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;

    assign cnt_next    = cnt_q + 1'b1;
    assign alarm_hit_o = adv_i && (BUS_W'(cnt_next) == alarm_i);

    always_ff @(posedge clk) begin
        if (rst || restart_i) cnt_q <= '0;
        else if (adv_i)       cnt_q <= cnt_next;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/rtt_regs.sv
module rtt_regs
    import rtt_pkg::*;
#(
    parameter int PRESC_W = 16,
    parameter int CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic               adv_i,
    input  logic               alarm_hit_i,
    output logic [PRESC_W-1:0] period_o,
    output logic [BUS_W-1:0]   alarm_o,
    output logic               restart_o,
    output irq_en_t            en_o,
    output flags_t             flags_o,
    output logic               irq_o
);
    reg_sel_e           sel;
    logic               wr_en;
    logic               rd_en;
    logic [PRESC_W-1:0] period_q;
    logic [BUS_W-1:0]   alarm_q;
    irq_en_t            en_q;
    flags_t             flags_q;
    logic               status_rd;

    assign sel       = decode_addr(bus_addr);
    assign wr_en     = bus_sel && bus_wr;
    assign rd_en     = bus_sel && !bus_wr;
    assign status_rd = rd_en && (sel == SEL_STATUS);
    assign restart_o = wr_en && (sel == SEL_MODE) && bus_wdata[BIT_RESTART];

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            en_q     <= '0;
            alarm_q  <= ALARM_OFF;
        end else if (wr_en) begin
            if (sel == SEL_MODE) begin
                period_q    <= bus_wdata[PRESC_W-1:0];
                en_q.alm_en <= bus_wdata[BIT_ALM_EN];
                en_q.inc_en <= bus_wdata[BIT_INC_EN];
            end
            if (sel == SEL_ALARM) alarm_q <= bus_wdata;
        end
    end

    // an event in the read cycle wins over the clear
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            if (alarm_hit_i)    flags_q.alm <= 1'b1;
            else if (status_rd) flags_q.alm <= 1'b0;
            if (adv_i)          flags_q.inc <= 1'b1;
            else if (status_rd) flags_q.inc <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_MODE: begin
                    bus_rdata[MODE_PRESC_W-1:0] = MODE_PRESC_W'(period_q);
                    bus_rdata[BIT_ALM_EN]       = en_q.alm_en;
                    bus_rdata[BIT_INC_EN]       = en_q.inc_en;
                end
                SEL_ALARM:  bus_rdata = alarm_q;
                SEL_VALUE:  bus_rdata = BUS_W'(cnt_i);
                SEL_STATUS: begin
                    bus_rdata[BIT_ALM_FLAG] = flags_q.alm;
                    bus_rdata[BIT_INC_FLAG] = flags_q.inc;
                end
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign irq_o    = (flags_q.alm && en_q.alm_en) || (flags_q.inc && en_q.inc_en);
    assign period_o = period_q;
    assign alarm_o  = alarm_q;
    assign en_o     = en_q;
    assign flags_o  = flags_q;

endmodule

// File: rtl/rtt_timer.sv
module rtt_timer
    import rtt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PRESC_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        slow_clk_i,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o
);
    logic               slow_tick;
    logic               adv;
    logic               restart;
    logic               alarm_hit;
    logic [PRESC_W-1:0] period;
    logic [PRESC_W-1:0] phase;
    logic [BUS_W-1:0]   alarm_val;
    logic [CNT_W-1:0]   cnt_q;
    irq_en_t            en;
    flags_t             flags;

    rtt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (slow_clk_i),
        .tick_o  (slow_tick)
    );

    rtt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (slow_tick),
        .restart_i (restart),
        .period_i  (period),
        .adv_o     (adv),
        .phase_o   (phase)
    );

    rtt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .adv_i       (adv),
        .restart_i   (restart),
        .alarm_i     (alarm_val),
        .cnt_o       (cnt_q),
        .alarm_hit_o (alarm_hit)
    );

    rtt_regs #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cnt_i       (cnt_q),
        .adv_i       (adv),
        .alarm_hit_i (alarm_hit),
        .period_o    (period),
        .alarm_o     (alarm_val),
        .restart_o   (restart),
        .en_o        (en),
        .flags_o     (flags),
        .irq_o       (irq_o)
    );

endmodule

// File: rtl/rtt_timer_checker.sv
module rtt_timer_checker #(
    parameter int CNT_W   = 32,
    parameter int PRESC_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [3:0]         bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               irq_o,
    input logic               adv,
    input logic [CNT_W-1:0]   cnt_q,
    input logic [PRESC_W-1:0] phase,
    input logic [1:0]         en,
    input logic [1:0]         flags
);
    logic rd_stat;
    logic wr_restart;
    logic wr_value;

    assign rd_stat    = bus_sel && !bus_wr && (bus_addr == 4'hC);
    assign wr_restart = bus_sel && bus_wr && (bus_addr == 4'h0) && bus_wdata[18];
    assign wr_value   = bus_sel && bus_wr && (bus_addr == 4'h8);

    a_r4_restart_clears: assert property (@(posedge clk) disable iff (rst)
        wr_restart |=> (cnt_q == '0) && (phase == '0));

    a_r5_value_read_only: assert property (@(posedge clk) disable iff (rst)
        (wr_value && !adv) |=> $stable(cnt_q));

    a_r7_inc_flag_set: assert property (@(posedge clk) disable iff (rst)
        adv |=> flags[1]);

    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !adv) |=> (flags == 2'b00));

    a_r10_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (en == 2'b00) |-> !irq_o);

    a_r11_single_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q)) |->
            ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0)));

endmodule

bind rtt_timer rtt_timer_checker #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .adv       (adv),
    .cnt_q     (cnt_q),
    .phase     (phase),
    .en        (en),
    .flags     (flags)
);

// File: tb/rtt_timer_test.sv
module rtt_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 4;
    localparam int PW = 4;

    localparam int NV = 6;
    localparam int VP [NV] = '{1, 2, 3, 4, 5, 7};
    localparam int VN [NV] = '{5, 7, 9, 3, 11, 14};
    localparam int VE [NV] = '{5, 3, 3, 0, 2, 2};

    logic        clk = 0;
    logic        rst = 1;
    logic        slow = 0;
    logic        sel = 0;
    logic        wr = 0;
    logic [3:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic        irq;
    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    logic [31:0] d;

    rtt_timer #(.CNT_W(CW), .PRESC_W(PW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .slow_clk_i(slow), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        sel = 1; wr = 1; addr = a; wdata = v;
        @(negedge clk);
        sel = 0; wr = 0;
    endtask

    task automatic bread(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        sel = 1; wr = 0; addr = a;
        #1 v = rdata;
        @(negedge clk);
        sel = 0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow = 1;
            repeat (3) @(negedge clk);
            slow = 0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic restart(input int p, input logic [31:0] en_bits);
        bwrite(4'h0, en_bits | 32'h0004_0000 | 32'(p));
        bread(4'hC, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        bread(4'h0, d); check("R1 mode", d, 32'h0);
        bread(4'h4, d); check("R1 alarm", d, 32'hFFFF_FFFF);
        bread(4'h8, d); check("R1 value", d, 32'h0);
        bread(4'hC, d); check("R1 status", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 / R7 vector walk
        for (int k = 0; k < NV; k++) begin
            restart(VP[k], 32'h0);
            pulses(VN[k]);
            bread(4'h8, d); check("R2 count", d, 32'(VE[k]));
            bread(4'hC, d); check("R7 inc flag", d, (VE[k] > 0) ? 32'h2 : 32'h0);
        end

        // R4 restart bit reads back 0
        bread(4'h0, d); check("R4 mode readback", d, 32'h7);

        // R3 prescaler 0 -> 16 edges
        restart(0, 32'h0);
        pulses(15);
        bread(4'h8, d); check("R3 before period", d, 32'h0);
        pulses(1);
        bread(4'h8, d); check("R3 at period", d, 32'h1);

        // R4 restart clears counter and prescaler phase
        restart(1, 32'h0);
        pulses(3);
        restart(1, 32'h0);
        bread(4'h8, d); check("R4 counter cleared", d, 32'h0);
        restart(3, 32'h0);
        pulses(2);
        restart(3, 32'h0);
        pulses(2);
        bread(4'h8, d); check("R4 phase cleared", d, 32'h0);

        // R5 value register is read-only
        restart(1, 32'h0);
        pulses(2);
        bwrite(4'h8, 32'h9);
        bread(4'h8, d); check("R5 write ignored", d, 32'h2);

        // R6 wrap
        restart(1, 32'h0);
        pulses(17);
        bread(4'h8, d); check("R6 wrap", d, 32'h1);

        // R8 / R10 alarm
        restart(1, 32'h0001_0000);
        bwrite(4'h4, 32'h3);
        pulses(2);
        check("R10 irq before alarm", {31'b0, irq}, 32'h0);
        bread(4'hC, d); check("R8 no early alarm", d, 32'h2);
        pulses(1);
        check("R10 irq on alarm", {31'b0, irq}, 32'h1);
        bread(4'hC, d); check("R8 alarm flag", d, 32'h3);
        check("R10 irq cleared", {31'b0, irq}, 32'h0);

        // R10 masking and level behaviour
        bwrite(4'h0, 32'h0000_0001);
        pulses(1);
        check("R10 masked", {31'b0, irq}, 32'h0);
        bwrite(4'h0, 32'h0002_0001);
        check("R10 inc enable", {31'b0, irq}, 32'h1);
        bread(4'hC, d);
        bwrite(4'h0, 32'h0000_0001);

        // R9 event in the same cycle as a status read is kept
        restart(1, 32'h0);
        @(negedge clk); slow = 1;
        @(negedge clk);
        @(negedge clk);
        sel = 1; wr = 0; addr = 4'hC;
        @(negedge clk);
        sel = 0;
        repeat (4) @(negedge clk);
        slow = 0;
        repeat (4) @(negedge clk);
        bread(4'hC, d); check("R9 collision kept", d, 32'h2);
        bread(4'hC, d); check("R9 read clears", d, 32'h0);

        // R11 narrow slow pulses each counted once
        restart(1, 32'h0);
        for (int i = 0; i < 9; i++) begin
            @(negedge clk); slow = 1;
            repeat (2) @(negedge clk);
            slow = 0;
            repeat (2) @(negedge clk);
        end
        bread(4'h8, d); check("R11 every edge once", d, 32'h9);

        summary();
    end
endmodule